// File: doc/BRIEF.md
# Two-wire slave with addressless turnaround

This block is the target side of a two-wire serial bus in the style of common inter-chip buses. It watches an SCL/SDA pair, oversampled by a system clock at least sixteen times faster than SCL. It picks out start, repeated-start and stop conditions and compares the first byte of each transaction against a fixed 7-bit device address. When the address matches it acknowledges. Written bytes go to the host logic through a one-cycle strobe. Read bytes are requested from the host through a request/load handshake and shifted out on SDA. SDA is driven only as an open-drain pull-down enable.

The feature that sets it apart is direction reversal inside one transaction. Once this slave has been selected, a repeated start does not need a second address byte. If the slave was receiving, it starts transmitting at once. If it was transmitting, including after the master has ended a read with a NACK, it goes back to receiving. A slave that saw a different address stays silent until a stop, and repeated starts do not wake it.

Clock stretching, arbitration, 10-bit addresses and general call are not supported.

Top module: `twb_slave`

## Requirements
- R1: A start is SDA falling while SCL is high, and it begins address reception. A stop is SDA rising while SCL is high. A stop ends the transaction, deselects the slave and leaves sda_oe low.
- R2: The first byte after a start is sent MSB first. Bits 7..1 are the address and bit 0 is the direction (0 = write, 1 = read). When bits 7..1 equal DEV_ADDR, the slave pulls SDA low during the ninth SCL high phase.
- R3: On an address mismatch the slave never drives SDA until the next stop. This holds even when a repeated start is followed by this slave's own address.
- R4: Each byte written after a write address is delivered MSB first on wr_data, with wr_valid high for exactly one cycle. The slave also acknowledges that byte on the ninth clock.
- R5: In read mode, rd_req pulses for one cycle before each byte. The host returns the byte on rd_data with rd_load high for one cycle, before the next SCL fall. The byte appears on SDA MSB first, and sda_oe changes only while SCL is low, except when a start or stop releases it.
- R6: After a read byte, SDA low from the master in the ninth clock (ACK) causes another rd_req and another byte. SDA high (NACK) makes the slave release SDA and keep it released until a start or stop.
- R7: When a selected slave in write mode sees a repeated start, rd_req pulses at once. The next byte is transmitted with no address byte in between.
- R8: When a selected slave in read mode, including after a NACK, sees a repeated start, it returns to write mode with no address byte. It then acknowledges and delivers the bytes that follow.
- R9: During and right after the synchronous active-high reset, sda_oe, wr_valid and rd_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_valid | output | 1 | One-cycle strobe when a written byte is ready |
| wr_data | output | DATA_W | Written byte, valid while wr_valid is high |
| rd_req | output | 1 | One-cycle request for the next byte to send |
| rd_load | input | 1 | Host strobe that captures rd_data |
| rd_data | input | DATA_W | Byte to transmit |

## Verification
Two functions meet in a single cycle. The first is the repeated-start detection, which both drops the write side and raises the read request. The second is the SCL fall that ends a received byte, which delivers wr_valid and starts the acknowledge pull-down in the same cycle. The bench provokes the first by placing a repeated start directly after an acknowledged write byte. It judges the result by the byte that comes back without any address, and an assertion checks that the request follows the start detection in the next cycle. The second is judged by an assertion that ties wr_valid to sda_oe, and by the bench comparing the delivered byte with the acknowledge it sampled on the bus.

// File: rtl/twb_pkg.sv
package twb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,    // no transaction
    ST_RX,      // shifting in a byte (address or data)
    ST_RX_ACK,  // driving acknowledge for a received byte
    ST_TX,      // shifting out a byte
    ST_TX_ACK,  // sampling the master's ACK/NACK
    ST_TURN,    // repeated start flipped us to transmit
    ST_DONE,    // read ended by NACK, waiting for start/stop
    ST_WAIT     // not addressed, silent until stop
  } twb_state_e;
endpackage

// File: rtl/twb_line_sync.sv
module twb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/twb_shift.sv
module twb_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         ser_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[W-2:0], ser_in};
  end
endmodule

// File: rtl/twb_slave.sv
module twb_slave
  import twb_pkg::*;
#(
  parameter int                DATA_W      = 8,
  parameter logic [DATA_W-2:0] DEV_ADDR    = 7'h52,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              wr_valid,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_req,
  input  logic              rd_load,
  input  logic [DATA_W-1:0] rd_data
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  twb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twb_state_e        st;
  logic [CNT_W-1:0]  bit_cnt;
  logic              full, is_addr, sel, rdir, more;
  logic [DATA_W-1:0] tx_buf, sh_q;
  logic              sh_load, sh_shift, sh_in;

  // shifter control: receive on SCL rise, transmit on SCL fall
  always_comb begin
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    sh_in    = 1'b0;
    if (!start_det && !stop_det) begin
      if (scl_fall && ((st == ST_RX_ACK && rdir) || (st == ST_TX_ACK && more) || st == ST_TURN))
        sh_load = 1'b1;
      else if (scl_rise && st == ST_RX && !full) begin
        sh_shift = 1'b1;
        sh_in    = sda_s;
      end else if (scl_fall && st == ST_TX && bit_cnt != LAST)
        sh_shift = 1'b1;
    end
  end

  twb_shift #(.W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load(sh_load), .load_val(tx_buf),
    .shift(sh_shift), .ser_in(sh_in), .q(sh_q)
  );

  always_ff @(posedge clk) begin
    if (rst) tx_buf <= '1;
    else if (rd_load) tx_buf <= rd_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      bit_cnt  <= '0;
      full     <= 1'b0;
      is_addr  <= 1'b0;
      sel      <= 1'b0;
      rdir     <= 1'b0;
      more     <= 1'b0;
      sda_oe   <= 1'b0;
      wr_valid <= 1'b0;
      wr_data  <= '0;
      rd_req   <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      rd_req   <= 1'b0;
      if (stop_det) begin
        st     <= ST_IDLE;
        sel    <= 1'b0;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        sda_oe  <= 1'b0;
        bit_cnt <= '0;
        full    <= 1'b0;
        if (st == ST_WAIT) begin
          st <= ST_WAIT;
        end else if (sel && !rdir) begin
          rdir   <= 1'b1;        // turnaround: now transmit
          rd_req <= 1'b1;
          st     <= ST_TURN;
        end else if (sel) begin
          rdir    <= 1'b0;       // turnaround: back to receive
          is_addr <= 1'b0;
          st      <= ST_RX;
        end else begin
          is_addr <= 1'b1;
          st      <= ST_RX;
        end
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise && !full) begin
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == LAST) full <= 1'b1;
            end else if (scl_fall && full) begin
              full    <= 1'b0;
              bit_cnt <= '0;
              if (is_addr) begin
                if (sh_q[DATA_W-1:1] == DEV_ADDR) begin
                  sel    <= 1'b1;
                  rdir   <= sh_q[0];
                  sda_oe <= 1'b1;
                  st     <= ST_RX_ACK;
                end else begin
                  st <= ST_WAIT;
                end
              end else begin
                wr_valid <= 1'b1;
                wr_data  <= sh_q;
                sda_oe   <= 1'b1;
                st       <= ST_RX_ACK;
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_rise && rdir) begin
              rd_req <= 1'b1;
            end else if (scl_fall) begin
              is_addr <= 1'b0;
              bit_cnt <= '0;
              if (rdir) begin
                sda_oe <= ~tx_buf[DATA_W-1];
                st     <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt == LAST) begin
                sda_oe <= 1'b0;
                st     <= ST_TX_ACK;
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
                sda_oe  <= ~sh_q[DATA_W-2];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              more <= ~sda_s;
              if (!sda_s) rd_req <= 1'b1;
            end else if (scl_fall) begin
              bit_cnt <= '0;
              if (more) begin
                sda_oe <= ~tx_buf[DATA_W-1];
                st     <= ST_TX;
              end else begin
                st <= ST_DONE;
              end
            end
          end
          ST_TURN: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              sda_oe  <= ~tx_buf[DATA_W-1];
              st      <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1: a stop always leaves SDA released
  p_stop_release_r1: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R3: an unaddressed slave never drives the bus
  p_wait_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT) |-> !sda_oe);

  // R4: a delivered byte is acknowledged in the same cycle
  p_ack_with_data_r4: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> sda_oe);

  // R5: SDA drive changes only while SCL is low, start/stop aside
  p_scl_low_change_r5: assert property (@(posedge clk) disable iff (rst)
    ((sda_oe != $past(sda_oe)) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_s));

  // R6: after a NACK the slave stays released
  p_nack_release_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DONE) |-> !sda_oe);

  // R7: turnaround start asks the host for data next cycle
  p_turn_req_r7: assert property (@(posedge clk) disable iff (rst)
    (start_det && !stop_det && sel && !rdir && st != ST_WAIT) |=> rd_req);
endmodule

// File: tb/twb_slave_bench.sv
module twb_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] MY_ADDR = 7'h52;
  // vector: {address[6:0], data[7:0], expect_ack}
  localparam logic [15:0] VEC [0:3] = '{
    {7'h52, 8'hA5, 1'b1},
    {7'h53, 8'h0F, 1'b0},
    {7'h52, 8'h3C, 1'b1},
    {7'h12, 8'hFF, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, wr_valid, rd_req;
  logic rd_load = 1'b0;
  logic [7:0] wr_data;
  logic [7:0] rd_data = 8'h00;
  logic sda_bus;

  assign sda_bus = sda_m & ~sda_oe;

  twb_slave #(.DATA_W(8), .DEV_ADDR(MY_ADDR), .SYNC_STAGES(2)) u_twb_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
    .rd_load(rd_load), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0;
  int fails = 0;
  int wr_cnt = 0;
  int rd_idx = 0;
  bit done = 1'b0;
  logic [7:0] wr_last = 8'h00;
  logic [7:0] rd_q [0:3] = '{8'h96, 8'h5B, 8'hC3, 8'h00};

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write monitor and read responder
  initial forever begin
    @(posedge clk); #1;
    if (wr_valid) begin wr_cnt++; wr_last = wr_data; end
  end
  initial forever begin
    @(posedge clk); #1;
    if (rd_req) begin
      rd_data = rd_q[rd_idx];
      rd_idx++;
      rd_load = 1'b1;
    end else rd_load = 1'b0;
  end

  task automatic bus_bit(input logic b, output logic s);
    scl_m = 1'b0; wait_clk(4);
    sda_m = b;    wait_clk(6);
    scl_m = 1'b1; wait_clk(5);
    s = sda_bus;  wait_clk(5);
  endtask

  task automatic bus_start();
    scl_m = 1'b0; wait_clk(4);
    sda_m = 1'b1; wait_clk(6);
    scl_m = 1'b1; wait_clk(6);
    sda_m = 1'b0; wait_clk(6);
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; wait_clk(4);
    sda_m = 1'b0; wait_clk(6);
    scl_m = 1'b1; wait_clk(6);
    sda_m = 1'b1; wait_clk(6);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      b[i] = s;
    end
    bus_bit(~m_ack, s);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    int wr_before;

    // R9: reset state
    wait_clk(5);
    chk("R9 sda_oe in reset", sda_oe, 0);
    rst = 1'b0;
    wait_clk(3);
    chk("R9 sda_oe after reset", sda_oe, 0);
    chk("R9 wr_valid after reset", wr_valid, 0);
    chk("R9 rd_req after reset", rd_req, 0);

    // table walk: write transactions, R2 / R3 / R4
    for (int v = 0; v < 4; v++) begin
      wr_before = wr_cnt;
      bus_start();
      send_byte({VEC[v][15:9], 1'b0}, ack);
      chk("R2 address ack", ack, VEC[v][0]);
      send_byte(VEC[v][8:1], ack);
      chk("R4 data ack", ack, VEC[v][0]);
      if (VEC[v][0]) begin
        chk("R4 one strobe", wr_cnt - wr_before, 1);
        chk("R4 data value", wr_last, VEC[v][8:1]);
      end else begin
        chk("R3 no strobe on mismatch", wr_cnt - wr_before, 0);
      end
      bus_stop();
      chk("R1 released after stop", sda_oe, 0);
    end

    // read with master ACK then NACK: R5 / R6
    bus_start();
    send_byte({MY_ADDR, 1'b1}, ack);
    chk("R2 read address ack", ack, 1);
    recv_byte(1'b1, rb);
    chk("R5 first read byte", rb, 8'h96);
    recv_byte(1'b0, rb);
    chk("R6 byte after ACK", rb, 8'h5B);
    chk("R6 two requests", rd_idx, 2);
    wait_clk(2);
    chk("R6 released after NACK", sda_oe, 0);
    bus_stop();

    // turnaround: write, Sr -> read, Sr -> write: R7 / R8
    bus_start();
    send_byte({MY_ADDR, 1'b0}, ack);
    chk("R2 turn address ack", ack, 1);
    send_byte(8'h11, ack);
    chk("R4 write before turn", wr_last, 8'h11);
    bus_start();
    recv_byte(1'b0, rb);
    chk("R7 read without address", rb, 8'hC3);
    chk("R7 request on turnaround", rd_idx, 3);
    bus_start();
    send_byte(8'h77, ack);
    chk("R8 ack after second turn", ack, 1);
    chk("R8 data after second turn", wr_last, 8'h77);
    bus_stop();
    chk("R1 released at end", sda_oe, 0);

    // mismatch followed by Sr carrying our address: R3
    bus_start();
    send_byte({7'h12, 1'b0}, ack);
    chk("R3 no ack on mismatch", ack, 0);
    bus_start();
    send_byte({MY_ADDR, 1'b1}, ack);
    chk("R3 Sr ignored after mismatch", ack, 0);
    chk("R3 no read request", rd_idx, 3);
    bus_stop();

    // fresh start after that is served again: R1
    bus_start();
    send_byte({MY_ADDR, 1'b0}, ack);
    chk("R1 fresh start after stop", ack, 1);
    bus_stop();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule